// File: doc/BRIEF.md
# Host power-management mailbox channel

This block is one byte-wide mailbox between a host processor and an embedded controller's firmware. The host side decodes two I/O offsets. One is a data port and the other a command/status port. A host write to either offset lands in the input buffer. A host read returns either the output buffer or a status byte. The firmware side reads the input buffer, writes the output buffer and loads a control word. The control word selects the interrupt enables, the interrupt scheme and how the host interrupt line is driven.

Two level-high interrupts go to the controller core, one for "output buffer empty" and one for "input buffer full". Their enables come from one of two enable pairs. A mode bit picks the pair, but only on the primary channel. Non-primary channels always use the channel-local pair. A single host interrupt line either follows the output-full flag or repeats a bit that firmware writes.

Top module: `pm_mailbox_channel`

## Requirements
- R1: After synchronous reset every register is 0: both flags clear, host_rdata is 0, all three interrupts are low.
- R2: A host write to DATA_PORT (default 0x62) stores host_wdata in the input buffer, sets IBF and clears the command flag on the next edge.
- R3: A host write to CMD_PORT (default 0x66) stores host_wdata in the input buffer, sets IBF and sets the command flag.
- R4: A host read of CMD_PORT returns the status byte on host_rdata one edge later. In that byte, bit 0 is OBF, bit 1 is IBF, bit 3 is the command flag and all other bits are 0. fw_status shows the same byte at all times.
- R5: A firmware write of the output buffer sets OBF. A host read of DATA_PORT returns the output buffer on host_rdata one edge later and clears OBF.
- R6: A firmware read of the input buffer clears IBF. When a host write comes in the same cycle, IBF stays 1 and the new byte is kept.
- R7: In enhanced mode (control bit 0 = 1), irq_obe equals (not OBF) AND control bit 1, and irq_ibf equals IBF AND control bit 2. Both are registered, so they lag the flags and the control word by one edge.
- R8: In compatible mode (control bit 0 = 0) on the primary channel, control bits 3 and 4 take the place of bits 1 and 2 as the output-empty and input-full enables.
- R9: On a channel built with PRIMARY = 0, control bit 0 is ignored and the enhanced enables (bits 1 and 2) always apply.
- R10: With control bit 5 = 0, host_irq equals control bit 6. With bit 5 = 1, host_irq follows OBF. In both cases the output is registered one edge behind its source.
- R11: A firmware output-buffer write and a host data-port read in the same cycle leave OBF set and return the old buffer contents to the host.
- R12: A host write to any other offset changes no state, and a host read of any other offset returns 0.
- R13: A firmware control write (fw_ctl_we) loads the 7-bit control word on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host I/O offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Registered host read byte |
| fw_rd_in | input | 1 | Firmware reads the input buffer (clears IBF) |
| fw_in_data | output | DATA_W | Input buffer contents |
| fw_status | output | DATA_W | Current status byte |
| fw_wr_out | input | 1 | Firmware writes the output buffer |
| fw_wdata | input | DATA_W | Firmware output byte |
| fw_ctl_we | input | 1 | Control word write strobe |
| fw_ctl_wdata | input | 7 | Control word: 0 enh mode, 1/2 enh OBE/IBF enables, 3/4 compat OBE/IBF enables, 5 hw host IRQ enable, 6 fw host IRQ bit |
| irq_obe | output | 1 | Core output-buffer-empty interrupt |
| irq_ibf | output | 1 | Core input-buffer-full interrupt |
| host_irq | output | 1 | Host interrupt line |

## Verification
Flags, buffers and the control word change on the edge that samples the strobe. host_rdata also updates on that edge and carries the pre-edge contents. The three interrupt outputs are registered from the flags and the control word, so they appear one edge after those change. The bench drives every stimulus for one full cycle starting at a falling edge, updates a behavioural model on the rising edge with these latencies, and compares every output at the next falling edge. A second instance built as a non-primary channel gets the same stimulus, and its interrupts are compared against the model's non-primary rule.

// File: rtl/pm_mbx_pkg.sv
package pm_mbx_pkg;
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;

  typedef struct packed {
    logic hirq_fw;
    logic hirq_hw_en;
    logic ibf_ie_cmp;
    logic obe_ie_cmp;
    logic ibf_ie_enh;
    logic obe_ie_enh;
    logic enh_mode;
  } pm_ctl_t;

  localparam int CTL_W = $bits(pm_ctl_t);
endpackage

// File: rtl/pm_mbx_flags.sv
module pm_mbx_flags #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              fw_rd_in,
  input  logic              fw_wr_out,
  input  logic [DATA_W-1:0] fw_wdata,
  output logic [DATA_W-1:0] in_buf,
  output logic [DATA_W-1:0] status,
  output logic              obf,
  output logic              ibf
);
  import pm_mbx_pkg::*;

  logic [DATA_W-1:0] out_buf;
  logic cmd_flag;
  logic hit_data, hit_cmd, wr_any;

  assign hit_data = (host_addr == DATA_PORT);
  assign hit_cmd  = (host_addr == CMD_PORT);
  assign wr_any   = host_wr && (hit_data || hit_cmd);

  always_comb begin
    status = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_CMD] = cmd_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_buf     <= '0;
      out_buf    <= '0;
      host_rdata <= '0;
      obf        <= 1'b0;
      ibf        <= 1'b0;
      cmd_flag   <= 1'b0;
    end else begin
      if (wr_any) begin
        in_buf   <= host_wdata;
        cmd_flag <= hit_cmd;
      end
      if (wr_any) ibf <= 1'b1;
      else if (fw_rd_in) ibf <= 1'b0;
      if (fw_wr_out) begin
        out_buf <= fw_wdata;
        obf     <= 1'b1;
      end else if (host_rd && hit_data) begin
        obf <= 1'b0;
      end
      if (host_rd) begin
        if (hit_data)     host_rdata <= out_buf;
        else if (hit_cmd) host_rdata <= status;
        else              host_rdata <= '0;
      end
    end
  end

  assert_ibf_set_R2: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> ibf);
  assert_ibf_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (fw_rd_in && !wr_any) |=> !ibf);
  assert_obf_set_R5: assert property (@(posedge clk) disable iff (rst)
    fw_wr_out |=> obf);
  assert_obf_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (host_rd && hit_data && !fw_wr_out) |=> !obf);
  assert_cmd_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hit_cmd) |=> status[ST_CMD]);
endmodule

// File: rtl/pm_mbx_irq.sv
module pm_mbx_irq #(
  parameter bit PRIMARY = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pm_mbx_pkg::pm_ctl_t  ctl,
  input  logic                 obf,
  input  logic                 ibf,
  output logic                 irq_obe,
  output logic                 irq_ibf,
  output logic                 host_irq
);
  logic enh_eff, obe_en, ibf_en;

  generate
    if (PRIMARY) begin : g_primary
      assign enh_eff = ctl.enh_mode;
    end else begin : g_secondary
      assign enh_eff = 1'b1;
    end
  endgenerate

  assign obe_en = enh_eff ? ctl.obe_ie_enh : ctl.obe_ie_cmp;
  assign ibf_en = enh_eff ? ctl.ibf_ie_enh : ctl.ibf_ie_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_obe  <= 1'b0;
      irq_ibf  <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      irq_obe  <= obe_en && !obf;
      irq_ibf  <= ibf_en && ibf;
      host_irq <= ctl.hirq_hw_en ? obf : ctl.hirq_fw;
    end
  end

  assert_hirq_hw_R10: assert property (@(posedge clk) disable iff (rst)
    ctl.hirq_hw_en |=> (host_irq == $past(obf)));
  assert_hirq_fw_R10: assert property (@(posedge clk) disable iff (rst)
    !ctl.hirq_hw_en |=> (host_irq == $past(ctl.hirq_fw)));
  assert_ibf_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (enh_eff && ctl.ibf_ie_enh && ibf) |=> irq_ibf);
  assert_no_irq_full_R7: assert property (@(posedge clk) disable iff (rst)
    obf |=> !irq_obe);
endmodule

// File: rtl/pm_mailbox_channel.sv
module pm_mailbox_channel #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66,
  parameter bit PRIMARY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              fw_rd_in,
  output logic [DATA_W-1:0] fw_in_data,
  output logic [DATA_W-1:0] fw_status,
  input  logic              fw_wr_out,
  input  logic [DATA_W-1:0] fw_wdata,
  input  logic              fw_ctl_we,
  input  logic [6:0]        fw_ctl_wdata,
  output logic              irq_obe,
  output logic              irq_ibf,
  output logic              host_irq
);
  import pm_mbx_pkg::*;

  pm_ctl_t ctl_q;
  logic obf, ibf;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (fw_ctl_we) ctl_q <= pm_ctl_t'(fw_ctl_wdata[CTL_W-1:0]);
  end

  pm_mbx_flags #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_flags (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .fw_rd_in(fw_rd_in), .fw_wr_out(fw_wr_out), .fw_wdata(fw_wdata),
    .in_buf(fw_in_data), .status(fw_status), .obf(obf), .ibf(ibf)
  );

  pm_mbx_irq #(.PRIMARY(PRIMARY)) u_irq (
    .clk(clk), .rst(rst), .ctl(ctl_q), .obf(obf), .ibf(ibf),
    .irq_obe(irq_obe), .irq_ibf(irq_ibf), .host_irq(host_irq)
  );

  assert_ctl_load_R13: assert property (@(posedge clk) disable iff (rst)
    fw_ctl_we |=> (ctl_q == $past(fw_ctl_wdata[CTL_W-1:0])));
endmodule

// File: tb/test_pm_mailbox_channel.sv
module test_pm_mailbox_channel;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] host_addr = '0, host_wdata = '0, fw_wdata = '0;
  logic host_wr = 0, host_rd = 0, fw_rd_in = 0, fw_wr_out = 0, fw_ctl_we = 0;
  logic [6:0] fw_ctl_wdata = '0;
  logic [7:0] host_rdata, fw_in_data, fw_status, s_rdata, s_in, s_st;
  logic irq_obe, irq_ibf, host_irq, s_obe, s_ibf, s_hirq;

  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  pm_mailbox_channel i_pm_mailbox_channel (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .fw_rd_in(fw_rd_in),
    .fw_in_data(fw_in_data), .fw_status(fw_status), .fw_wr_out(fw_wr_out),
    .fw_wdata(fw_wdata), .fw_ctl_we(fw_ctl_we), .fw_ctl_wdata(fw_ctl_wdata),
    .irq_obe(irq_obe), .irq_ibf(irq_ibf), .host_irq(host_irq));

  pm_mailbox_channel #(.PRIMARY(1'b0)) i_pm_mailbox_channel_sec (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(s_rdata), .fw_rd_in(fw_rd_in),
    .fw_in_data(s_in), .fw_status(s_st), .fw_wr_out(fw_wr_out),
    .fw_wdata(fw_wdata), .fw_ctl_we(fw_ctl_we), .fw_ctl_wdata(fw_ctl_wdata),
    .irq_obe(s_obe), .irq_ibf(s_ibf), .host_irq(s_hirq));

  // behavioural model
  int m_in = 0, m_out = 0, m_rd = 0, m_ctl = 0;
  bit m_obf = 0, m_ibf = 0, m_cmd = 0;
  bit m_iobe = 0, m_iibf = 0, m_hirq = 0, m_sobe = 0, m_sibf = 0;

  function automatic int stat_byte();
    return (m_obf ? 1 : 0) + (m_ibf ? 2 : 0) + (m_cmd ? 8 : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_in = 0; m_out = 0; m_rd = 0; m_ctl = 0;
      m_obf = 0; m_ibf = 0; m_cmd = 0;
      m_iobe = 0; m_iibf = 0; m_hirq = 0; m_sobe = 0; m_sibf = 0;
    end else begin
      bit enh, oe, ie, is_data, is_cmd;
      enh = m_ctl[0];
      oe = enh ? m_ctl[1] : m_ctl[3];
      ie = enh ? m_ctl[2] : m_ctl[4];
      m_iobe = oe && !m_obf;
      m_iibf = ie && m_ibf;
      m_sobe = m_ctl[1] && !m_obf;
      m_sibf = m_ctl[2] && m_ibf;
      m_hirq = m_ctl[5] ? m_obf : m_ctl[6];
      is_data = (host_addr == 8'h62);
      is_cmd  = (host_addr == 8'h66);
      if (host_rd) m_rd = is_data ? m_out : (is_cmd ? stat_byte() : 0);
      if (host_wr && (is_data || is_cmd)) begin
        m_in = host_wdata; m_cmd = is_cmd; m_ibf = 1;
      end else if (fw_rd_in) m_ibf = 0;
      if (fw_wr_out) begin m_out = fw_wdata; m_obf = 1; end
      else if (host_rd && is_data) m_obf = 0;
      if (fw_ctl_we) m_ctl = fw_ctl_wdata;
    end
  end

  task automatic chk(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("host_rdata R4 R5", host_rdata, m_rd);
    chk("fw_in_data R2", fw_in_data, m_in);
    chk("fw_status R4", fw_status, stat_byte());
    chk("irq_obe R7 R8", irq_obe, m_iobe);
    chk("irq_ibf R7 R8", irq_ibf, m_iibf);
    chk("host_irq R10", host_irq, m_hirq);
    chk("sec irq_obe R9", s_obe, m_sobe);
    chk("sec irq_ibf R9", s_ibf, m_sibf);
  end

  task automatic op(bit hw, bit hr, logic [7:0] a, logic [7:0] hd,
                    bit fr, bit fw, logic [7:0] fd);
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_addr = a; host_wdata = hd;
    fw_rd_in = fr; fw_wr_out = fw; fw_wdata = fd;
    @(negedge clk);
    host_wr = 0; host_rd = 0; fw_rd_in = 0; fw_wr_out = 0;
  endtask

  task automatic ctl(logic [6:0] v);
    @(negedge clk); fw_ctl_we = 1; fw_ctl_wdata = v;
    @(negedge clk); fw_ctl_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    phase = "R1"; chk("reset status R1", fw_status, 0); chk("reset irq R1", host_irq, 0);
    phase = "R13"; ctl(7'b0000111); idle(2);
    phase = "R2"; op(1, 0, 8'h62, 8'hA5, 0, 0, 0); idle(2);
    phase = "R4"; op(0, 1, 8'h66, 0, 0, 0, 0); idle(1);
    phase = "R6"; op(0, 0, 0, 0, 1, 0, 0); idle(2);
    phase = "R3"; op(1, 0, 8'h66, 8'h81, 0, 0, 0); op(0, 1, 8'h66, 0, 0, 0, 0); idle(1);
    phase = "R6"; op(1, 0, 8'h62, 8'h5C, 1, 0, 0); idle(2);
    op(0, 0, 0, 0, 1, 0, 0); idle(1);
    phase = "R5";
    for (int i = 0; i < 6; i++) begin
      op(0, 0, 0, 0, 0, 1, 8'(8'h11 * i + 3)); idle(1);
      op(0, 1, 8'h66, 0, 0, 0, 0);
      op(0, 1, 8'h62, 0, 0, 0, 0); idle(1);
    end
    phase = "R11"; op(0, 0, 0, 0, 0, 1, 8'h77);
    op(0, 1, 8'h62, 0, 0, 1, 8'h99); idle(2);
    op(0, 1, 8'h62, 0, 0, 0, 0); idle(2);
    phase = "R8"; ctl(7'b0011000); idle(2);
    op(1, 0, 8'h66, 8'h42, 0, 0, 0); idle(2);
    op(0, 0, 0, 0, 1, 0, 0); idle(2);
    phase = "R9"; ctl(7'b0000110); idle(2);
    op(1, 0, 8'h62, 8'h24, 0, 0, 0); idle(2);
    phase = "R10"; ctl(7'b1000000); idle(2); ctl(7'b0000000); idle(2);
    ctl(7'b0100000); idle(1);
    op(0, 0, 0, 0, 0, 1, 8'h3E); idle(2);
    op(0, 1, 8'h62, 0, 0, 0, 0); idle(2);
    phase = "R12"; op(1, 0, 8'h60, 8'hEE, 0, 0, 0); idle(1);
    op(0, 1, 8'h64, 0, 0, 0, 0); idle(2);
    op(0, 1, 8'h66, 0, 0, 0, 0); idle(2);
    phase = "R1"; @(negedge clk); rst = 1; idle(2); @(negedge clk); rst = 0; idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual=%0d expected=done", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule